// File: doc/BRIEF.md
# Pseudo-SRAM power sequencer

This block drives the two power-related enables of an asynchronous pseudo-SRAM: the secondary enable (`ce2`, active high, low means power-down) and a hold that forces the primary chip enable to its inactive (high) level. After reset it keeps `ce2` low for a programmable power-up time. It then raises `ce2` while still holding the primary enable inactive for a long settling time. Only after that does it raise `ready`, which tells the access controller that read and write cycles may begin.

In the ready state the access controller owns the primary enable. A power-down entry request is a one-cycle pulse. It is remembered until the block is ready and the access controller reports idle. The block then forces the primary enable high for a setup time, drops `ce2`, and keeps it low for at least a minimum time. An exit request is also a pulse and is remembered. Once the minimum low time has passed, `ce2` rises again. The same long settling hold as at power-up then runs before `ready` returns. While `ready` is low the access controller must leave its data lines undriven.

All times are counts of the block clock (nominally 10 ns per cycle), and every state shares one down-counter.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, `ce2` is 0, `ce1_hold` is 1 and `ready` is 0.
- R2: After reset is released, `ce2` stays low for exactly PU_LOW_CYC clock cycles, with `ce1_hold` high throughout.
- R3: `ce2` only rises while `ce1_hold` is high, and it was high in the cycle before.
- R4: `ready` is only ever high while `ce2` is high, and `ce1_hold` is 0 exactly when `ready` is 1.
- R5: When an entry request (pulse or pending) meets `ctrl_idle`=1 in the ready state:
  - `ready` falls and `ce1_hold` rises one cycle later.
  - `ce2` falls PD_SETUP_CYC cycles after that.
  - `ce1_hold` is already high in the cycle before `ce2` falls.
- R6: An entry request made while `ctrl_idle` is 0 is kept pending. `ready` and `ce2` stay high until `ctrl_idle` goes to 1, and the entry then starts on the next cycle.
- R7: An entry request made during the power-up sequence is kept pending. It is honoured once `ready` is high and `ctrl_idle` is 1.
- R8: Once in power-down, `ce2` stays low for at least PD_MIN_CYC cycles. An exit request made early ends the low time after exactly PD_MIN_CYC cycles.
- R9: Without an exit request, `ce2` stays low indefinitely. An exit pulse given after the minimum low time has passed raises `ce2` one cycle later.
- R10: An exit pulse given in the last cycle of the minimum low time is honoured without an extra cycle: `ce2` rises PD_MIN_CYC cycles after the low time began.
- R11: After `ce2` rises, from power-up or from power-down exit, `ready` rises after exactly PU_HOLD_CYC cycles. `ce1_hold` stays high until then.
- R12: Requests that come at the wrong time have no effect:
  - An exit pulse outside power-down is ignored.
  - An entry pulse while already entering or in power-down is ignored, so `ready` stays high after the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_idle | input | 1 | Access controller is in standby with its enables inactive |
| pd_enter | input | 1 | One-cycle request to enter power-down |
| pd_exit | input | 1 | One-cycle request to leave power-down |
| ce2 | output | 1 | Secondary enable to the memory; low selects power-down |
| ce1_hold | output | 1 | Forces the primary chip enable inactive (high) |
| ready | output | 1 | Accesses may be issued |

## Verification
Two pairs of events can land in the same cycle:
- An exit request and the last cycle of the minimum power-down time. The bench places the exit pulse exactly on the cycle in which the low time would have expired. It then counts the cycles until `ce2` rises and compares that count with the count for an early request: the two must be equal.
- An entry request and the access controller turning idle. The bench holds `ctrl_idle` low while pulsing entry, then raises it. It judges that `ready` falls on the very next cycle, and not earlier.

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int unsigned PU_LOW_CYC   = 5000,
  parameter int unsigned PU_HOLD_CYC  = 35000,
  parameter int unsigned PD_SETUP_CYC = 1,
  parameter int unsigned PD_MIN_CYC   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_idle,
  input  logic pd_enter,
  input  logic pd_exit,
  output logic ce2,
  output logic ce1_hold,
  output logic ready
);

  localparam int unsigned M1   = (PU_LOW_CYC > PU_HOLD_CYC) ? PU_LOW_CYC : PU_HOLD_CYC;
  localparam int unsigned M2   = (PD_SETUP_CYC > PD_MIN_CYC) ? PD_SETUP_CYC : PD_MIN_CYC;
  localparam int unsigned MAXC = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_PU_LOW, S_PU_HOLD, S_RUN, S_PD_SETUP, S_PD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          enter_pend, exit_pend;

  wire expired  = (cnt == '0);
  wire in_pd    = (st == S_PD_SETUP) || (st == S_PD);
  wire go_pd    = (st == S_RUN) && (enter_pend || pd_enter) && ctrl_idle;
  wire go_up    = (st == S_PD) && expired && (exit_pend || pd_exit);

  assign ce2      = (st == S_PU_HOLD) || (st == S_RUN) || (st == S_PD_SETUP);
  assign ready    = (st == S_RUN);
  assign ce1_hold = !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_PU_LOW;
      cnt <= CW'(PU_LOW_CYC - 1);
    end else begin
      case (st)
        S_PU_LOW:
          if (expired) begin
            st  <= S_PU_HOLD;
            cnt <= CW'(PU_HOLD_CYC - 1);
          end else cnt <= cnt - CW'(1);
        S_PU_HOLD:
          if (expired) st <= S_RUN;
          else cnt <= cnt - CW'(1);
        S_RUN:
          if (go_pd) begin
            st  <= S_PD_SETUP;
            cnt <= CW'(PD_SETUP_CYC - 1);
          end
        S_PD_SETUP:
          if (expired) begin
            st  <= S_PD;
            cnt <= CW'(PD_MIN_CYC - 1);
          end else cnt <= cnt - CW'(1);
        S_PD:
          if (go_up) begin
            st  <= S_PU_HOLD;
            cnt <= CW'(PU_HOLD_CYC - 1);
          end else if (!expired) cnt <= cnt - CW'(1);
        default: st <= S_PU_LOW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enter_pend <= 1'b0;
      exit_pend  <= 1'b0;
    end else begin
      enter_pend <= (go_pd || in_pd) ? 1'b0 : (enter_pend || pd_enter);
      exit_pend  <= (in_pd && !go_up) ? (exit_pend || pd_exit) : 1'b0;
    end
  end

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int unsigned PU_LOW_CYC   = 5000,
  parameter int unsigned PU_HOLD_CYC  = 35000,
  parameter int unsigned PD_SETUP_CYC = 1,
  parameter int unsigned PD_MIN_CYC   = 7
) (
  input logic clk,
  input logic rst_n,
  input logic ce2,
  input logic ce1_hold,
  input logic ready
);

  localparam int unsigned MIN_LOW = (PU_LOW_CYC < PD_MIN_CYC) ? PU_LOW_CYC : PD_MIN_CYC;
  localparam int unsigned TOP     = (PU_LOW_CYC > PU_HOLD_CYC) ? PU_LOW_CYC : PU_HOLD_CYC;
  localparam int unsigned TOPM    = (TOP > PD_MIN_CYC) ? TOP : PD_MIN_CYC;
  localparam int unsigned W       = $clog2(TOPM + 2);

  logic [W-1:0] lo_run, hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      if (ce2) lo_run <= '0;
      else if (lo_run != W'(TOPM + 1)) lo_run <= lo_run + W'(1);
      if (!ce2) hi_run <= '0;
      else if (!ready && hi_run != W'(TOPM + 1)) hi_run <= hi_run + W'(1);
    end
  end

  a_r3_ce1_high_at_ce2_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2) |-> (ce1_hold && $past(ce1_hold)));

  a_r4_ready_needs_ce2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ce2);

  a_r5_ce1_high_before_ce2_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce2) |-> (ce1_hold && $past(ce1_hold)));

  a_r8_min_low_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2) |-> (lo_run >= W'(MIN_LOW)));

  a_r11_hold_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (hi_run >= W'(PU_HOLD_CYC)));

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .PU_LOW_CYC(PU_LOW_CYC), .PU_HOLD_CYC(PU_HOLD_CYC),
  .PD_SETUP_CYC(PD_SETUP_CYC), .PD_MIN_CYC(PD_MIN_CYC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ce2(ce2), .ce1_hold(ce1_hold), .ready(ready)
);

// File: tb/test_psram_pwr_seq.sv
module test_psram_pwr_seq;
  localparam int unsigned PUL = 20, PUH = 40, SET = 2, PDM = 7;

  logic clk = 1'b0, rst_n = 1'b0, ctrl_idle = 1'b0, pd_enter = 1'b0, pd_exit = 1'b0;
  logic ce2, ce1_hold, ready;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  psram_pwr_seq #(.PU_LOW_CYC(PUL), .PU_HOLD_CYC(PUH), .PD_SETUP_CYC(SET), .PD_MIN_CYC(PDM))
    i_psram_pwr_seq (.clk(clk), .rst_n(rst_n), .ctrl_idle(ctrl_idle), .pd_enter(pd_enter),
                     .pd_exit(pd_exit), .ce2(ce2), .ce1_hold(ce1_hold), .ready(ready));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0: ce2, 1: ready, 2: ce1_hold. Counts negedges from now until the signal equals val.
  task automatic wait_for(input int sel, input logic val, output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if ((sel == 0 ? ce2 : sel == 1 ? ready : ce1_hold) == val) return;
    end
    n = -1;
  endtask

  task automatic pulse_enter();
    pd_enter = 1'b1; @(posedge clk); #1 pd_enter = 1'b0;
  endtask

  task automatic pulse_exit();
    pd_exit = 1'b1; @(posedge clk); #1 pd_exit = 1'b0;
  endtask

  task automatic steady(input string req, input int cycles);
    bit ok = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!(ready && ce2 && !ce1_hold)) ok = 1'b0;
    end
    chk(req, ok, 1);
  endtask

  task automatic t_reset_powerup();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ce2", ce2, 0); chk("R1 ce1_hold", ce1_hold, 1); chk("R1 ready", ready, 0);
    rst_n = 1'b1;
    wait_for(0, 1'b1, n);
    chk("R2 ce2 low cycles", n, PUL);
    chk("R3 ce1_hold at ce2 rise", ce1_hold, 1);
    wait_for(1, 1'b1, n);
    chk("R11 hold cycles at power-up", n, PUH);
    chk("R4 ce1 released when ready", ce1_hold, 0);
  endtask

  task automatic t_enter(output int first_low);
    int n;
    ctrl_idle = 1'b1;
    pulse_enter();
    @(negedge clk);
    chk("R5 ready falls", ready, 0); chk("R5 ce1_hold rises", ce1_hold, 1);
    chk("R5 ce2 still high", ce2, 1);
    wait_for(0, 1'b0, n);
    chk("R5 ce2 fall delay", n + 1, SET + 1);
    first_low = n;
  endtask

  task automatic t_exit_early();
    int n, d;
    t_enter(d);
    pulse_exit();
    wait_for(0, 1'b1, n);
    chk("R8 early exit low time", n, PDM);
    wait_for(1, 1'b1, n);
    chk("R11 hold after exit", n, PUH);
  endtask

  task automatic t_exit_last_cycle();
    int n, d;
    t_enter(d);
    repeat (PDM - 1) @(negedge clk);
    chk("R10 still low before last cycle", ce2, 0);
    pulse_exit();
    wait_for(0, 1'b1, n);
    chk("R10 last-cycle exit", n, 1);
    wait_for(1, 1'b1, n);
    chk("R11 hold after last-cycle exit", n, PUH);
  endtask

  task automatic t_stay_down();
    int n, d;
    t_enter(d);
    repeat (PDM + 20) @(negedge clk);
    chk("R9 stays in power-down", ce2, 0);
    chk("R9 ready low in power-down", ready, 0);
    pulse_exit();
    wait_for(0, 1'b1, n);
    chk("R9 late exit", n, 1);
    wait_for(1, 1'b1, n);
    chk("R11 hold after late exit", n, PUH);
  endtask

  task automatic t_busy_pending();
    int n;
    ctrl_idle = 1'b0;
    pulse_enter();
    steady("R6 held while busy", 12);
    ctrl_idle = 1'b1;
    wait_for(1, 1'b0, n);
    chk("R6 entry on idle", n, 1);
    wait_for(0, 1'b0, n);
    pulse_exit();
    wait_for(1, 1'b1, n);
  endtask

  task automatic t_pending_powerup();
    int n;
    ctrl_idle = 1'b0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pulse_enter();
    wait_for(1, 1'b1, n);
    chk("R7 ready after power-up", n > 0, 1);
    steady("R7 pending kept while busy", 6);
    ctrl_idle = 1'b1;
    wait_for(1, 1'b0, n);
    chk("R7 pending honoured", n, 1);
    wait_for(0, 1'b0, n);
    pulse_exit();
    wait_for(1, 1'b1, n);
  endtask

  task automatic t_ignored();
    int n, d;
    ctrl_idle = 1'b1;
    pulse_exit();
    steady("R12 exit ignored outside power-down", 10);
    t_enter(d);
    pulse_enter();
    pulse_exit();
    wait_for(1, 1'b1, n);
    steady("R12 entry ignored during power-down", 15);
  endtask

  initial begin
    t_reset_powerup();
    t_exit_early();
    t_exit_last_cycle();
    t_stay_down();
    t_busy_pending();
    t_pending_powerup();
    t_ignored();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule